// File: doc/BRIEF.md
# Cycle Timer with Compare Interrupt

This block keeps a 32-bit count of elapsed core cycles next to a 32-bit target value and raises a timer interrupt once the count reaches or passes the target. The count moves in one of two ways: a single-cycle step that adds one, or a sampled step in which the core presents its running cycle number and the block adds whatever has elapsed since the previous sample. Because a sampled step may add many cycles at once, the match is judged as a crossing between the count before and after the step, using wrap-safe signed differences, so no jump can skip over the target.

Software may load either register at any time. Any such load first drops the pending interrupt and then stores the new value, which is how a handler acknowledges the timer. The pending flag is also presented on a small vector of interrupt lines, where it sits on line 7 for the interrupt controller downstream.

Top module: `cmp_timer`

## Requirements
- R1: After reset, the count, the target and the pending flag are zero, and the stored sample reference is zero, so the first sampled step adds the full presented cycle number.
- R2: A cycle with `incOne` high, `sampleEn` low and no write adds exactly 1 to the count, modulo 2^32.
- R3: A cycle with `sampleEn` high and no write adds (`coreCycles` minus the stored reference) modulo 2^32 to the count; every cycle with `sampleEn` high stores `coreCycles` as the new reference.
- R4: On an advancing cycle the pending flag is set when, as 32-bit two's-complement values, (target minus count before) is greater than zero and (target minus count after) is at most zero; otherwise no new interrupt is raised.
- R5: Once set, the pending flag stays set through later advances and idle cycles until a register write.
- R6: A write to the count (`countWrEn`) or to the target (`compareWrEn`) stores all 32 bits of `wrData` and clears the pending flag in the same cycle; both may be written together.
- R7: In a cycle with any write, the count does not advance and no crossing is tested, even if `sampleEn` or `incOne` is high; the sample reference is still updated when `sampleEn` is high.
- R8: When `sampleEn` and `incOne` are both high with no write, the sampled step is used and the single step is ignored.
- R9: `irqLines` carries the pending flag on bit 7 only; all other bits are zero, and `timerIrq` equals the pending flag.
- R10: Counting with single steps across the 0xFFFFFFFF to 0 wrap toward a target just past zero raises the interrupt exactly once, on the step that reaches the target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| incOne | input | 1 | Advance the count by one this cycle |
| sampleEn | input | 1 | Advance by cycles elapsed since the last sample |
| coreCycles | input | 32 | Running core cycle number, used with `sampleEn` |
| countWrEn | input | 1 | Load the count from `wrData` |
| compareWrEn | input | 1 | Load the target from `wrData` |
| wrData | input | 32 | Write value |
| countVal | output | 32 | Current count |
| compareVal | output | 32 | Current target |
| timerIrq | output | 1 | Pending timer interrupt |
| irqLines | output | 8 | Interrupt line vector, timer on bit 7 |

## Verification
The crossing test is driven with sampled jumps that stop short of the target, jumps that leap over it, single steps that land exactly on it, and a target placed more than half the range ahead; together these separate a true crossing test from a plain equality check or an unsigned comparison. Writes coinciding with sampled or single steps show whether writes win and whether the reference still moves, and simultaneous sampled and single steps show which step source is chosen. A single-step run over the 32-bit wrap counts rising edges of the interrupt to show it fires once and then holds.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic wrCount;    // load count from write data
    logic wrCompare;  // load target from write data
    logic doAdvance;  // apply the step to the count and test for a crossing
    logic useRef;     // step = coreCycles - reference, else step = 1
    logic latchRef;   // capture coreCycles as the new reference
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       incOne,
  input  logic       sampleEn,
  input  logic       countWrEn,
  input  logic       compareWrEn,
  input  logic       crossHit,
  output tmrStrobe_t strobe,
  output logic       pending
);
  logic anyWr;

  assign anyWr = countWrEn | compareWrEn;

  always_comb begin
    strobe.wrCount   = countWrEn;
    strobe.wrCompare = compareWrEn;
    // writes take priority: no step and no crossing test in a write cycle
    strobe.doAdvance = !anyWr && (sampleEn || incOne);
    // sampled step wins over the single step
    strobe.useRef    = sampleEn;
    strobe.latchRef  = sampleEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          pending <= 1'b0;
    else if (anyWr)     pending <= 1'b0;
    else if (crossHit)  pending <= 1'b1;
  end

  // R5: pending holds until a write
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    pending && !anyWr |=> pending);
  // R6: any write leaves the flag clear
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    anyWr |=> !pending);
  // R4: the flag only rises on an advancing cycle
  a_r4_rise_on_step: assert property (@(posedge clk) disable iff (!rstN)
    !pending && !strobe.doAdvance |=> !pending);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strobe,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] coreCycles,
  output logic [W-1:0] countVal,
  output logic [W-1:0] compareVal,
  output logic         crossHit
);
  logic [W-1:0] countQ, compareQ, refQ;
  logic [W-1:0] stepVal, countNext;
  logic signed [W-1:0] gapBefore, gapAfter;

  assign stepVal   = strobe.useRef ? (coreCycles - refQ) : W'(1);
  assign countNext = countQ + stepVal;
  assign gapBefore = $signed(compareQ - countQ);
  assign gapAfter  = $signed(compareQ - countNext);
  assign crossHit  = strobe.doAdvance && (gapBefore > 0) && (gapAfter <= 0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= '0;
      compareQ <= '0;
      refQ     <= '0;
    end else begin
      if (strobe.wrCount)        countQ <= wrData;
      else if (strobe.doAdvance) countQ <= countNext;
      if (strobe.wrCompare)      compareQ <= wrData;
      if (strobe.latchRef)       refQ <= coreCycles;
    end
  end

  assign countVal   = countQ;
  assign compareVal = compareQ;

  // R6: a count write stores the write data
  a_r6_count_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCount |=> countQ == $past(wrData));
  // R2: single step adds one
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAdvance && !strobe.useRef |=> countQ == $past(countQ) + W'(1));
  // R7: without a step or a count write the count holds
  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doAdvance && !strobe.wrCount |=> $stable(countQ));
  // R6: the target only changes through a write
  a_r6_compare_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCompare |=> $stable(compareQ));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int W         = 32,
  parameter int IRQ_LINES = 8,
  parameter int IRQ_LINE  = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 incOne,
  input  logic                 sampleEn,
  input  logic [W-1:0]         coreCycles,
  input  logic                 countWrEn,
  input  logic                 compareWrEn,
  input  logic [W-1:0]         wrData,
  output logic [W-1:0]         countVal,
  output logic [W-1:0]         compareVal,
  output logic                 timerIrq,
  output logic [IRQ_LINES-1:0] irqLines
);
  tmrStrobe_t strobe;
  logic       crossHit;
  logic       pending;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .incOne(incOne), .sampleEn(sampleEn),
    .countWrEn(countWrEn), .compareWrEn(compareWrEn),
    .crossHit(crossHit), .strobe(strobe), .pending(pending)
  );

  tmr_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .coreCycles(coreCycles), .countVal(countVal),
    .compareVal(compareVal), .crossHit(crossHit)
  );

  assign timerIrq = pending;

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
    if (i == IRQ_LINE) begin : g_timer
      assign irqLines[i] = pending;
    end else begin : g_idle
      assign irqLines[i] = 1'b0;
    end
  end

  // R9: at most the timer line is active
  a_r9_single_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));
endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        incOne = 1'b0, sampleEn = 1'b0;
  logic [31:0] coreCycles = '0;
  logic        countWrEn = 1'b0, compareWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] countVal, compareVal;
  logic        timerIrq;
  logic [7:0]  irqLines;

  always #2.5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rstN(rstN), .incOne(incOne), .sampleEn(sampleEn),
    .coreCycles(coreCycles), .countWrEn(countWrEn), .compareWrEn(compareWrEn),
    .wrData(wrData), .countVal(countVal), .compareVal(compareVal),
    .timerIrq(timerIrq), .irqLines(irqLines)
  );

  typedef struct {
    logic [31:0] cnt;
    logic [31:0] cmp;
    logic        irq;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int total = 0, bad = 0;
  logic [31:0] mCount = '0, mCompare = '0, mRef = '0;
  logic        mPend = 1'b0;
  logic        wrapWin = 1'b0, prevIrq = 1'b0;
  int          riseCnt = 0;
  bit          done = 1'b0;

  function automatic void check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  // driver: apply one cycle of stimulus and push the expected result
  task automatic op(input logic cw, input logic pw, input logic [31:0] d,
                    input logic smp, input logic [31:0] cyc, input logic inc, input string tag);
    logic [31:0] step, nxt;
    logic adv;
    expItem_t it;
    @(negedge clk);
    countWrEn = cw; compareWrEn = pw; wrData = d;
    sampleEn = smp; coreCycles = cyc; incOne = inc;
    step = smp ? cyc - mRef : 32'd1;
    adv  = !(cw || pw) && (smp || inc);
    nxt  = mCount + step;
    if (cw || pw) mPend = 1'b0;
    else if (adv && $signed(mCompare - mCount) > 0 && $signed(mCompare - nxt) <= 0) mPend = 1'b1;
    if (cw) mCount = d; else if (adv) mCount = nxt;
    if (pw) mCompare = d;
    if (smp) mRef = cyc;
    it.cnt = mCount; it.cmp = mCompare; it.irq = mPend; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 32'd0, 1'b0, 32'd0, 1'b0, tag);
  endtask

  // monitor: compare just after each active edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(e.tag, countVal, e.cnt, "count");
      check(e.tag, compareVal, e.cmp, "compare");
      check(e.tag, {31'd0, timerIrq}, {31'd0, e.irq}, "irq");
      check({e.tag, "/R9"}, {24'd0, irqLines}, {24'd0, e.irq, 7'd0}, "irqLines");
    end
  end

  always @(negedge clk) begin
    if (wrapWin && timerIrq && !prevIrq) riseCnt++;
    prevIrq = timerIrq;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", countVal, 32'd0, "count");
    check("R1", compareVal, 32'd0, "compare");
    check("R1", {24'd0, irqLines}, 32'd0, "irqLines");
    // R1/R3: first sample counts from zero
    op(0, 0, 0, 1, 32'd5, 0, "R3");
    for (int i = 0; i < 3; i++) op(0, 0, 0, 0, 0, 1, "R2");
    op(0, 0, 0, 1, 32'd12, 0, "R3");
    op(0, 1, 32'd40, 0, 0, 0, "R6");
    op(0, 0, 0, 1, 32'd32, 0, "R4");      // 35, short of 40
    op(0, 0, 0, 1, 32'd50, 0, "R4");      // jumps over 40
    op(0, 0, 0, 0, 0, 1, "R5");
    idle("R5");
    op(1, 0, 32'd100, 1, 32'd60, 0, "R7"); // write wins, reference moves
    op(0, 1, 32'd103, 0, 0, 0, "R6");
    op(0, 0, 0, 1, 32'd62, 1, "R8");      // step 2, not 1
    op(0, 0, 0, 0, 0, 1, "R4");           // lands exactly on 103
    op(0, 1, 32'd200, 0, 0, 1, "R7");     // clears, count holds
    op(0, 1, 32'd103 + 32'h8000_0001, 0, 0, 0, "R6");
    op(0, 0, 0, 1, 32'd72, 0, "R4");      // target far ahead: no fire
    op(1, 1, 32'hFFFF_FFF0, 0, 0, 0, "R6");
    op(0, 1, 32'd1, 0, 0, 0, "R6");
    op(1, 0, 32'hFFFF_FFFD, 0, 0, 0, "R6");
    wait (expQ.size() == 0);
    wrapWin = 1'b1;
    for (int i = 0; i < 8; i++) op(0, 0, 0, 0, 0, 1, "R10");
    idle("R10");
    wait (expQ.size() == 0);
    @(negedge clk);
    wrapWin = 1'b0;
    check("R10", riseCnt, 32'd1, "irq rises");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule